// File: doc/BRIEF.md
# Alarm Time Setter and Match Indicator

This block keeps an alarm time made of an hour and a minute, each stored as two BCD digits. While the alarm mode is active, two push buttons step the alarm hour and the alarm minute. A short press steps once. If the button is held long enough, the block starts stepping on every fast strobe. A clear request restores the alarm time to 12:00.

The block watches the running clock digits. When they reach the alarm hour and minute at second 00, and the arm switch is on, an indicator rises. The indicator stays high for a fixed number of one-second strobes. Turning the arm switch off suppresses the indicator, and also cuts short an indication that is already running.

The one-second and fast strobes are single-cycle pulses that the surrounding clock logic supplies.

Top module: `alarm_match_unit`

## Requirements
- R1: After the synchronous active-high reset, the alarm hour reads 8'h12, the alarm minute reads 8'h00 and the indicator is low. Digits are packed BCD: bits [7:4] hold the tens and bits [3:0] hold the ones.
- R2: While the mode is active, the rising edge of the hour button (active high) advances the alarm hour by one. The new value appears two clock edges after the button is first sampled high. The hour runs 00 to 23 and wraps from 23 to 00.
- R3: The minute button advances the alarm minute in the same way as R2. The minute runs 00 to 59 and wraps from 59 to 00. A minute wrap leaves the alarm hour unchanged.
- R4: A button counts as held once HOLD_TICKS one-second strobes (default 2) have arrived while it stays pressed. From then on, each fast strobe steps the value once more. Before that point, fast strobes do nothing.
- R5: When the mode is inactive, button presses and fast strobes leave the alarm digits unchanged.
- R6: A clear request while the mode is active sets the alarm time to 12:00. The same request with the mode inactive has no effect.
- R7: The indicator rises one clock edge after all of the following first hold together: clock hour equals the alarm hour, clock minute equals the alarm minute, clock second is 8'h00, and arm is high. It does not rise if the minute differs or the second is not 00.
- R8: Once raised, the indicator falls on the RING_SECS-th one-second strobe that follows (default 10).
- R9: The indicator fires once per match. While the clock digits stay at the matching value, it does not rise again.
- R10: With arm low, a match raises nothing. Dropping arm during an indication clears the indicator at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_active | input | 1 | High while the alarm mode is selected |
| clear_req | input | 1 | Restore the alarm time to 12:00 (only in mode) |
| sec_tick | input | 1 | One-cycle strobe once per second |
| fast_tick | input | 1 | One-cycle strobe for fast setting (100 ms) |
| btn_hour | input | 1 | Hour set button, active high |
| btn_min | input | 1 | Minute set button, active high |
| arm | input | 1 | Alarm enable switch |
| tod_hour | input | 8 | Running clock hour, BCD |
| tod_min | input | 8 | Running clock minute, BCD |
| tod_sec | input | 8 | Running clock second, BCD |
| alm_hour | output | 8 | Alarm hour, BCD |
| alm_min | output | 8 | Alarm minute, BCD |
| ring | output | 1 | Alarm indicator |

## Verification
The hardest situation to reach from the ports is the switch from single steps to fast stepping. It depends on counting one-second strobes while a button stays down, and on fast strobes arriving both before and after that point. The bench holds a button down, issues fast strobes that must have no effect, then issues the qualifying one-second strobes, and finally counts the steps that each later fast strobe produces.

The second hard case is a single match minute during which the clock digits sit unchanged for the whole indication. The bench freezes the clock digits at the match and counts one-second strobes up to the fall. It then checks that no second indication follows.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DIGW = 8;
  typedef logic [DIGW-1:0] bcd2_t;

  // next value of a two-digit BCD counter with the given maximum
  function automatic bcd2_t bcd2_next(bcd2_t v, bcd2_t maxv);
    bcd2_t r;
    if (v == maxv)             r = '0;
    else if (v[3:0] == 4'd9)   r = {v[7:4] + 4'd1, 4'd0};
    else                       r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/key_repeat.sv
module key_repeat #(
  parameter int HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic key,
  input  logic slow_tick,
  input  logic fast_tick,
  output logic step
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_TICKS);

  logic          key_q;
  logic [CW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) key_q <= 1'b0;
    else     key_q <= key;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable || !key)              held <= '0;
    else if (slow_tick && held != HOLD_V)    held <= held + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) step <= 1'b0;
    else     step <= enable && key && (!key_q || (held == HOLD_V && fast_tick));
  end

  // R5
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> $past(enable));
  // R4
  hold_bound_chk: assert property (@(posedge clk) disable iff (rst)
    held <= HOLD_V);
endmodule

// File: rtl/bcd2_counter.sv
module bcd2_counter
  import alarm_pkg::*;
#(
  parameter int MAX_VAL  = 23,
  parameter int INIT_VAL = 12
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clear,
  input  logic  step,
  output bcd2_t value
);
  localparam bcd2_t MAX_B  = bcd2_t'(((MAX_VAL / 10) << 4) | (MAX_VAL % 10));
  localparam bcd2_t INIT_B = bcd2_t'(((INIT_VAL / 10) << 4) | (INIT_VAL % 10));

  always_ff @(posedge clk) begin
    if (rst || clear) value <= INIT_B;
    else if (step)    value <= bcd2_next(value, MAX_B);
  end

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    value <= MAX_B && value[3:0] <= 4'd9);
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && value == MAX_B) |=> value == '0);
endmodule

// File: rtl/ring_timer.sv
module ring_timer #(
  parameter int RING_SECS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic match,
  input  logic sec_tick,
  output logic ring
);
  localparam int RW = $clog2(RING_SECS + 1);
  localparam logic [RW-1:0] RING_V = RW'(RING_SECS);

  logic [RW-1:0] remain;
  logic          match_q;
  logic          fire;

  assign fire = arm && match && !match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match;
      if (!arm)                          remain <= '0;
      else if (fire)                     remain <= RING_V;
      else if (sec_tick && remain != '0) remain <= remain - 1'b1;
    end
  end

  assign ring = (remain != '0);

  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ring) |-> $past(match) && $past(arm));
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    remain <= RING_V);
  // R8
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ring) |-> $past(sec_tick) || !$past(arm));
  // R10
  arm_off_chk: assert property (@(posedge clk) disable iff (rst)
    !arm |=> !ring);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int HOLD_TICKS = 2,
  parameter int RING_SECS  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_active,
  input  logic       clear_req,
  input  logic       sec_tick,
  input  logic       fast_tick,
  input  logic       btn_hour,
  input  logic       btn_min,
  input  logic       arm,
  input  logic [7:0] tod_hour,
  input  logic [7:0] tod_min,
  input  logic [7:0] tod_sec,
  output logic [7:0] alm_hour,
  output logic [7:0] alm_min,
  output logic       ring
);
  localparam int NFIELD = 2;
  localparam int MAXV [NFIELD] = '{23, 59};
  localparam int INITV[NFIELD] = '{12, 0};

  logic  keys  [NFIELD];
  logic  steps [NFIELD];
  bcd2_t vals  [NFIELD];
  logic  clr;
  logic  match;

  assign keys[0] = btn_hour;
  assign keys[1] = btn_min;
  assign clr     = mode_active && clear_req;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    key_repeat #(.HOLD_TICKS(HOLD_TICKS)) u_key (
      .clk(clk), .rst(rst), .enable(mode_active), .key(keys[i]),
      .slow_tick(sec_tick), .fast_tick(fast_tick), .step(steps[i]));
    bcd2_counter #(.MAX_VAL(MAXV[i]), .INIT_VAL(INITV[i])) u_cnt (
      .clk(clk), .rst(rst), .clear(clr), .step(steps[i]), .value(vals[i]));
  end

  assign alm_hour = vals[0];
  assign alm_min  = vals[1];

  assign match = (tod_sec == 8'h00) && (tod_hour == alm_hour) && (tod_min == alm_min);

  ring_timer #(.RING_SECS(RING_SECS)) u_ring (
    .clk(clk), .rst(rst), .arm(arm), .match(match),
    .sec_tick(sec_tick), .ring(ring));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_active && clear_req) |=> alm_hour == 8'h12 && alm_min == 8'h00);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_active && !$past(mode_active)) |-> $stable(alm_hour) && $stable(alm_min));
endmodule

// File: tb/alarm_match_unit_tb_top.sv
module alarm_match_unit_tb_top;
  logic clk = 0, rst = 1, mode_active = 0, clear_req = 0, sec_tick = 0, fast_tick = 0;
  logic btn_hour = 0, btn_min = 0, arm = 0;
  logic [7:0] tod_hour = 8'h00, tod_min = 8'h00, tod_sec = 8'h01;
  logic [7:0] alm_hour, alm_min;
  logic ring;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  alarm_match_unit dut_i (.*);

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(bit hr);
    if (hr) btn_hour = 1; else btn_min = 1;
    cyc(3);
    btn_hour = 0; btn_min = 0;
    cyc(2);
  endtask

  task automatic pulse_sec();
    sec_tick = 1; cyc(1); sec_tick = 0; cyc(1);
  endtask

  task automatic pulse_fast();
    fast_tick = 1; cyc(1); fast_tick = 0; cyc(1);
  endtask

  task automatic do_clear();
    clear_req = 1; cyc(1); clear_req = 0; cyc(1);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    // R1 reset state
    chk("R1 hour", alm_hour, 8'h12);
    chk("R1 min", alm_min, 8'h00);
    chk("R1 ring", {7'd0, ring}, 8'h00);

    // R5 presses outside mode ignored
    press(1); press(0); pulse_fast();
    chk("R5 hour", alm_hour, 8'h12);
    chk("R5 min", alm_min, 8'h00);
    // R6 clear outside mode ignored: first change then request
    mode_active = 1;
    press(0);
    mode_active = 0;
    do_clear();
    chk("R6 ignored", alm_min, 8'h01);
    mode_active = 1;
    do_clear();
    chk("R6 clear min", alm_min, 8'h00);

    // R2 hour sweep with wrap 23->00
    for (int k = 1; k <= 25; k++) begin
      press(1);
      chk("R2 hour step", alm_hour, bcd((12 + k) % 24));
    end
    do_clear();
    // R3 minute sweep with wrap 59->00, no carry into hours
    for (int k = 1; k <= 61; k++) begin
      press(0);
      chk("R3 min step", alm_min, bcd(k % 60));
      chk("R3 no carry", alm_hour, 8'h12);
    end
    do_clear();
    chk("R6 clear hour", alm_hour, 8'h12);
    chk("R6 clear min2", alm_min, 8'h00);

    // R4 hold-to-repeat
    btn_hour = 1; cyc(3);
    chk("R4 first step", alm_hour, 8'h13);
    pulse_fast(); pulse_fast(); pulse_fast();
    chk("R4 fast before hold", alm_hour, 8'h13);
    pulse_sec();
    pulse_fast();
    chk("R4 one sec only", alm_hour, 8'h13);
    pulse_sec();
    for (int k = 1; k <= 12; k++) begin
      pulse_fast();
      chk("R4 fast step", alm_hour, bcd((13 + k) % 24));
    end
    btn_hour = 0; cyc(2);
    // R4 minute hold
    btn_min = 1; cyc(3);
    pulse_sec(); pulse_sec();
    for (int k = 0; k < 5; k++) pulse_fast();
    chk("R4 min fast", alm_min, 8'h06);
    btn_min = 0; cyc(2);
    // R5 fast strobes while held out of mode
    mode_active = 0;
    btn_min = 1; cyc(3); pulse_sec(); pulse_sec(); pulse_fast(); pulse_fast();
    btn_min = 0; cyc(2);
    chk("R5 held out of mode", alm_min, 8'h06);
    mode_active = 1;
    do_clear();
    mode_active = 0;

    // R7/R8/R9 alarm at 12:00
    arm = 1;
    tod_hour = 8'h11; tod_min = 8'h59; tod_sec = 8'h59; cyc(2);
    chk("R7 no ring before", {7'd0, ring}, 8'h00);
    tod_hour = 8'h12; tod_min = 8'h00; tod_sec = 8'h00; cyc(1);
    chk("R7 ring rises", {7'd0, ring}, 8'h01);
    for (int k = 1; k <= 9; k++) begin
      pulse_sec();
      chk("R8 ring held", {7'd0, ring}, 8'h01);
    end
    pulse_sec();
    chk("R8 ring falls", {7'd0, ring}, 8'h00);
    cyc(5); pulse_sec();
    chk("R9 no retrigger", {7'd0, ring}, 8'h00);

    // R7 mismatch minute, nonzero seconds
    tod_sec = 8'h30; cyc(2);
    tod_min = 8'h01; tod_sec = 8'h00; cyc(2);
    chk("R7 minute mismatch", {7'd0, ring}, 8'h00);
    tod_min = 8'h00; tod_sec = 8'h30; cyc(2);
    chk("R7 seconds nonzero", {7'd0, ring}, 8'h00);

    // R7 with set alarm 07:07
    mode_active = 1;
    for (int k = 0; k < 19; k++) press(1);
    for (int k = 0; k < 7; k++) press(0);
    mode_active = 0;
    chk("R2 set 07", alm_hour, 8'h07);
    tod_hour = 8'h07; tod_min = 8'h06; tod_sec = 8'h00; cyc(2);
    chk("R7 off by minute", {7'd0, ring}, 8'h00);
    tod_min = 8'h07; cyc(1);
    chk("R7 ring 07:07", {7'd0, ring}, 8'h01);

    // R10 arm drop clears at next edge
    arm = 0; cyc(1);
    chk("R10 cleared", {7'd0, ring}, 8'h00);
    tod_sec = 8'h01; cyc(2);
    tod_sec = 8'h00; cyc(2);
    chk("R10 disarmed match", {7'd0, ring}, 8'h00);
    arm = 1; cyc(2);
    chk("R10 rearm mid-match", {7'd0, ring}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule